// File: doc/BRIEF.md
# Video Pixel Input Format Unpacker

This block sits right after a raw video input bus. It turns each incoming word into aligned output samples with a one-cycle valid strobe. The output is a luma byte plus one chroma byte tagged as Cb or Cr for the YUV formats, or a 24-bit pixel for RGB.

A configuration byte `cfg_word` sets up the block:
- A format field in bits [4:2]: 3'h2 is 16-bit YUV, 3'h4 is 8-bit YUV, 3'h6 is RGB. Every other code is reserved.
- Bit 1 picks whether luma or chroma comes first.
- Bit 0 picks whether the first chroma byte of a line is Cb or Cr.
- Bit 6 enables a packed transport. In this transport the source inserts one dead word after every six data words, and the block discards it.
- Bits 7 and 5 are reserved.

The configuration byte is copied into a shadow register only on a `line_start` cycle. A line is therefore never decoded with a mixture of two configurations.

The control is a small state machine with four states:
- `ST_HALT`: the format is reserved or not yet configured. Nothing is emitted.
- `ST_WIDE`: one sample is emitted per accepted word (16-bit YUV and RGB).
- `ST_PAIR_A`: 8-bit YUV, holding the first byte of a pair.
- `ST_PAIR_B`: 8-bit YUV, completing the pair and emitting a sample.

The transitions are:
- `T_LINE_LOAD`: on `line_start`, every state enters the state that the new format selects.
- `T_BYTE_HOLD`: `ST_PAIR_A` goes to `ST_PAIR_B` on an accepted byte.
- `T_BYTE_PAIR`: `ST_PAIR_B` goes to `ST_PAIR_A` on an accepted byte.
- `ST_HALT` and `ST_WIDE` otherwise stay where they are.

Top module: `pxu_unpack`

## Requirements
- R1: After reset the shadow configuration is zero (a reserved format), so `o_valid` stays low for any input until a `line_start` loads a legal format.
- R2: A change of `cfg_word` on a cycle without `line_start` has no effect on the outputs until the next `line_start`.
- R3: In 16-bit YUV, each accepted word gives one sample one cycle later. With bit 1 = 0, chroma is `in_data[15:8]` and luma is `in_data[7:0]`. With bit 1 = 1 the two bytes swap roles.
- R4: In 8-bit YUV, bytes arrive on `in_data[7:0]`. Two consecutive accepted bytes form one sample, emitted one cycle after the second byte, so `o_valid` is never high on two consecutive cycles. With bit 1 = 0 the first byte is chroma; with bit 1 = 1 the first byte is luma.
- R5: In both YUV formats, `o_chroma_is_cb` alternates on every emitted sample. The first sample after `line_start` carries Cb (1) when bit 0 = 1 and Cr (0) when bit 0 = 0.
- R6: In RGB, each accepted word is passed to `o_rgb` as `in_data[23:0]` one cycle later, with `o_rgb_mode` = 1. In YUV samples `o_rgb_mode` = 0.
- R7: With a reserved format code (anything but 3'h2, 3'h4 and 3'h6 in bits [4:2]), `o_valid` stays low for the whole line.
- R8: With bit 6 = 1, after every six accepted data words the next accepted word is dropped and produces no sample. The count restarts at `line_start`. With bit 6 = 0 no word is dropped.
- R9: A `line_start` cycle carries no data. It restarts the byte-pair phase, the drop count and the chroma alternation, and `o_valid` is low in the following cycle.
- R10: A word is accepted only when `in_act` = 1. Cycles with `in_act` = 0 produce no sample and do not advance the pair phase or the drop count.
- R11: Bits 7 and 5 of `cfg_word` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 8 | Configuration byte, sampled on line_start |
| line_start | input | 1 | Start-of-line marker, no data on this cycle |
| in_act | input | 1 | Input word present |
| in_data | input | 24 | Raw input word |
| o_valid | output | 1 | Sample strobe |
| o_luma | output | 8 | Luma byte |
| o_chroma | output | 8 | Chroma byte |
| o_chroma_is_cb | output | 1 | 1 when o_chroma is Cb, 0 when Cr |
| o_rgb | output | 24 | RGB pixel |
| o_rgb_mode | output | 1 | 1 when the sample is RGB |

## Verification
The hardest situation to reach is the interaction of the packed-mode drop with the 8-bit byte pairing when `in_act` has gaps. The dropped word can fall between the two halves of a pair, and the six-word count must survive idle cycles. Only long lines with random `in_act` gaps under packed 8-bit YUV reach this, so the random phase draws many such lines. Directed lines then cover odd byte counts cut short by `line_start` and mid-line configuration writes.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 3;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int RUN_LEN = 6;

    // Format codes held in bits [4:2] of the configuration byte
    localparam logic [2:0] FMT_YUV16 = 3'h2;
    localparam logic [2:0] FMT_YUV8  = 3'h4;
    localparam logic [2:0] FMT_RGB   = 3'h6;

    // Bit layout follows the register decode of the neighbour that writes it
    typedef struct packed {
        logic       rsv_hi;      // bit 7, ignored
        logic       pack_en;     // bit 6, packed transport with dead word
        logic       rsv_mid;     // bit 5, ignored
        logic [2:0] fmt;         // bits 4:2
        logic       luma_first;  // bit 1
        logic       cb_first;    // bit 0
    } pxu_cfg_t;

    localparam logic [7:0] CFG_LIVE_MASK = 8'h5F;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_WIDE   = 2'd1,
        ST_PAIR_A = 2'd2,
        ST_PAIR_B = 2'd3
    } pxu_state_e;

    // State entered on a line start for a given format code
    function automatic pxu_state_e entry_state(input logic [2:0] fmt);
        pxu_state_e s;
        unique case (fmt)
            FMT_YUV16, FMT_RGB: s = ST_WIDE;
            FMT_YUV8:           s = ST_PAIR_A;
            default:            s = ST_HALT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pxu_cfg_shadow.sv
`timescale 1ns/1ps
// Holds the configuration used for the current line; loads only on line start.
module pxu_cfg_shadow
    import pxu_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [CFG_W-1:0] cfg_in,
    output pxu_cfg_t         cfg_next,
    output pxu_cfg_t         cfg_q
);

    // Reserved bits are cleared on the way in so they can never steer decode
    assign cfg_next = pxu_cfg_t'(cfg_in & CFG_LIVE_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (line_start) begin
            cfg_q <= cfg_next;
        end
    end

endmodule

// File: rtl/pxu_word_gate.sv
`timescale 1ns/1ps
// Accepts input words and discards the dead word of the packed transport.
module pxu_word_gate #(
    parameter int RUN = 6,
    localparam int CNT_W = $clog2(RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic word_in,
    input  logic pack_en,
    output logic word_take,
    output logic word_drop
);

    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN);

    logic [CNT_W-1:0] run_cnt;
    logic             live;

    assign live      = word_in && !line_start;
    assign word_drop = live && pack_en && (run_cnt == RUN_LAST);
    assign word_take = live && !word_drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (line_start) begin
            run_cnt <= '0;
        end else if (live && pack_en) begin
            if (run_cnt == RUN_LAST) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxu_unpack_fsm.sv
`timescale 1ns/1ps
// Control state machine and output sample registers.
module pxu_unpack_fsm
    import pxu_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NL = LANES,
    localparam int WW = BW * NL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  pxu_cfg_t      cfg_next,
    input  pxu_cfg_t      cfg_q,
    input  logic          word_take,
    input  logic [WW-1:0] in_data,
    output logic          o_valid,
    output logic [BW-1:0] o_luma,
    output logic [BW-1:0] o_chroma,
    output logic          o_chroma_is_cb,
    output logic [WW-1:0] o_rgb,
    output logic          o_rgb_mode
);

    logic [BW-1:0] lane [NL];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign lane[g] = in_data[g*BW +: BW];
    end

    pxu_state_e    state, state_nxt;
    logic [BW-1:0] held;
    logic          cb_next;
    logic [BW-1:0] first_b, second_b;
    logic          emit_yuv;

    // Next state: T_LINE_LOAD has priority, then byte-pair transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT:   state_nxt = ST_HALT;
            ST_WIDE:   state_nxt = ST_WIDE;
            ST_PAIR_A: if (word_take) state_nxt = ST_PAIR_B;   // T_BYTE_HOLD
            ST_PAIR_B: if (word_take) state_nxt = ST_PAIR_A;   // T_BYTE_PAIR
            default:   state_nxt = ST_HALT;
        endcase
        if (line_start) begin
            state_nxt = entry_state(cfg_next.fmt);             // T_LINE_LOAD
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // Byte selection: earlier byte and later byte of the sample
    always_comb begin
        first_b  = lane[1];
        second_b = lane[0];
        emit_yuv = 1'b0;
        unique case (state)
            ST_WIDE: begin
                first_b  = lane[1];
                second_b = lane[0];
                emit_yuv = word_take && (cfg_q.fmt == FMT_YUV16);
            end
            ST_PAIR_B: begin
                first_b  = held;
                second_b = lane[0];
                emit_yuv = word_take;
            end
            ST_HALT, ST_PAIR_A: begin
                first_b  = lane[1];
                second_b = lane[0];
                emit_yuv = 1'b0;
            end
            default: emit_yuv = 1'b0;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid        <= 1'b0;
            o_luma         <= '0;
            o_chroma       <= '0;
            o_chroma_is_cb <= 1'b0;
            o_rgb          <= '0;
            o_rgb_mode     <= 1'b0;
            held           <= '0;
            cb_next        <= 1'b0;
        end else begin
            o_valid <= 1'b0;
            if (line_start) begin
                cb_next <= cfg_next.cb_first;
            end else begin
                if (state == ST_PAIR_A && word_take) begin
                    held <= lane[0];
                end
                if (state == ST_WIDE && word_take && cfg_q.fmt == FMT_RGB) begin
                    o_valid    <= 1'b1;
                    o_rgb      <= in_data;
                    o_rgb_mode <= 1'b1;
                end
                if (emit_yuv) begin
                    o_valid        <= 1'b1;
                    o_rgb_mode     <= 1'b0;
                    o_luma         <= cfg_q.luma_first ? first_b  : second_b;
                    o_chroma       <= cfg_q.luma_first ? second_b : first_b;
                    o_chroma_is_cb <= cb_next;
                    cb_next        <= !cb_next;
                end
            end
        end
    end

endmodule

// File: rtl/pxu_unpack.sv
`timescale 1ns/1ps
module pxu_unpack
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_word,
    input  logic              line_start,
    input  logic              in_act,
    input  logic [WORD_W-1:0] in_data,
    output logic              o_valid,
    output logic [BYTE_W-1:0] o_luma,
    output logic [BYTE_W-1:0] o_chroma,
    output logic              o_chroma_is_cb,
    output logic [WORD_W-1:0] o_rgb,
    output logic              o_rgb_mode
);

    pxu_cfg_t cfg_next, cfg_q;
    logic     word_take, word_drop;
    logic [2:0] act_fmt;
    logic       act_pack;

    assign act_fmt  = cfg_q.fmt;
    assign act_pack = cfg_q.pack_en;

    pxu_cfg_shadow #(.CFG_W(8)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .cfg_in     (cfg_word),
        .cfg_next   (cfg_next),
        .cfg_q      (cfg_q)
    );

    pxu_word_gate #(.RUN(RUN_LEN)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .word_in    (in_act),
        .pack_en    (act_pack),
        .word_take  (word_take),
        .word_drop  (word_drop)
    );

    pxu_unpack_fsm #(.BW(BYTE_W), .NL(LANES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_start     (line_start),
        .cfg_next       (cfg_next),
        .cfg_q          (cfg_q),
        .word_take      (word_take),
        .in_data        (in_data),
        .o_valid        (o_valid),
        .o_luma         (o_luma),
        .o_chroma       (o_chroma),
        .o_chroma_is_cb (o_chroma_is_cb),
        .o_rgb          (o_rgb),
        .o_rgb_mode     (o_rgb_mode)
    );

endmodule

// File: rtl/pxu_unpack_chk.sv
`timescale 1ns/1ps
module pxu_unpack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       in_act,
    input logic       o_valid,
    input logic [2:0] act_fmt,
    input logic       act_pack,
    input logic       word_drop
);

    assert_valid_needs_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> $past(in_act && !line_start));

    assert_line_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !o_valid);

    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt != 3'h2 && act_fmt != 3'h4 && act_fmt != 3'h6) |=> !o_valid);

    assert_drop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_drop |=> !o_valid);

    assert_drop_packed_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_drop |-> act_pack);

    assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt == 3'h4 && o_valid) |=> !o_valid);

endmodule

bind pxu_unpack pxu_unpack_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .in_act     (in_act),
    .o_valid    (o_valid),
    .act_fmt    (act_fmt),
    .act_pack   (act_pack),
    .word_drop  (word_drop)
);

// File: tb/pxu_unpack_tb.sv
`timescale 1ns/1ps
module pxu_unpack_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_i = 8'h00;
    logic        ls_i = 1'b0;
    logic        act_i = 1'b0;
    logic [23:0] data_i = '0;
    logic        o_valid, o_chroma_is_cb, o_rgb_mode;
    logic [7:0]  o_luma, o_chroma;
    logic [23:0] o_rgb;

    pxu_unpack u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_i), .line_start(ls_i),
        .in_act(act_i), .in_data(data_i), .o_valid(o_valid), .o_luma(o_luma),
        .o_chroma(o_chroma), .o_chroma_is_cb(o_chroma_is_cb), .o_rgb(o_rgb),
        .o_rgb_mode(o_rgb_mode)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    // Bench model state, written from the requirements
    logic [7:0] m_cfg = 8'h00;
    int         m_cnt = 0;
    bit         m_phase = 0;
    logic [7:0] m_held = '0;
    bit         m_cbn = 0;
    bit         e_valid, e_rgbm, e_cb;
    logic [7:0] e_luma, e_chroma;
    logic [23:0] e_rgb;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [2:0] f);
        return f == 3'h2 || f == 3'h4 || f == 3'h6;
    endfunction

    task automatic model_step(input bit ls, input bit act, input logic [23:0] d);
        logic [2:0] f;
        logic [7:0] fb, sb;
        bit emit;
        e_valid = 0;
        emit = 0;
        fb = '0; sb = '0;
        f = m_cfg[4:2];
        if (ls) begin
            m_cfg = cfg_i;
            m_cnt = 0; m_phase = 0; m_cbn = cfg_i[0];
        end else if (act && legal(f)) begin
            if (m_cfg[6] && m_cnt == 6) begin
                m_cnt = 0;
            end else begin
                if (m_cfg[6]) m_cnt++;
                if (f == 3'h6) begin
                    e_valid = 1; e_rgbm = 1; e_rgb = d;
                end else if (f == 3'h2) begin
                    fb = d[15:8]; sb = d[7:0]; emit = 1;
                end else if (!m_phase) begin
                    m_held = d[7:0]; m_phase = 1;
                end else begin
                    fb = m_held; sb = d[7:0]; emit = 1; m_phase = 0;
                end
                if (emit) begin
                    e_valid = 1; e_rgbm = 0; e_cb = m_cbn; m_cbn = !m_cbn;
                    e_luma   = m_cfg[1] ? fb : sb;
                    e_chroma = m_cfg[1] ? sb : fb;
                end
            end
        end
    endtask

    // One clock: drive at negedge, compare at the following negedge
    task automatic cyc(input bit ls, input bit act, input logic [23:0] d);
        ls_i = ls; act_i = act; data_i = d;
        model_step(ls, act, d);
        @(posedge clk);
        @(negedge clk);
        chk(o_valid == e_valid, tag, "o_valid", 32'(o_valid), 32'(e_valid));
        if (e_valid && o_valid) begin
            chk(o_rgb_mode == e_rgbm, "R6", "o_rgb_mode", 32'(o_rgb_mode), 32'(e_rgbm));
            if (e_rgbm) begin
                chk(o_rgb == e_rgb, "R6", "o_rgb", 32'(o_rgb), 32'(e_rgb));
            end else begin
                chk(o_luma == e_luma, tag, "o_luma", 32'(o_luma), 32'(e_luma));
                chk(o_chroma == e_chroma, tag, "o_chroma", 32'(o_chroma), 32'(e_chroma));
                chk(o_chroma_is_cb == e_cb, "R5", "o_chroma_is_cb",
                    32'(o_chroma_is_cb), 32'(e_cb));
            end
        end
    endtask

    task automatic line(input logic [7:0] c, input int len, input int gap_pct);
        cfg_i = c;
        cyc(1, 0, 24'h0);
        for (int i = 0; i < len; i++) begin
            cyc(1'b0, ($urandom_range(99) >= gap_pct), 24'($urandom));
        end
    endtask

    function automatic string tag_for(input logic [7:0] c);
        if (!legal(c[4:2])) return "R7";
        if (c[6])            return "R8";
        if (c[4:2] == 3'h2)  return "R3";
        if (c[4:2] == 3'h4)  return "R4";
        return "R6";
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5A17));
        // R1: reset state and silence before a legal line start
        repeat (3) @(negedge clk);
        chk(o_valid == 0, "R1", "o_valid in reset", 32'(o_valid), 0);
        chk(o_rgb_mode == 0, "R1", "o_rgb_mode in reset", 32'(o_rgb_mode), 0);
        rst_n = 1'b1;
        tag = "R1";
        cfg_i = 8'h08;
        for (int i = 0; i < 6; i++) cyc(0, 1, 24'h00A0B0 + 24'(i));

        // R3: 16-bit YUV, both orders
        tag = "R3";
        line(8'h08, 8, 0);
        line(8'h0B, 8, 0);
        line(8'h09, 7, 30);

        // R2: mid-line rewrite of the configuration is ignored
        tag = "R2";
        cfg_i = 8'h08;
        cyc(1, 0, 0);
        cfg_i = 8'h18;
        for (int i = 0; i < 6; i++) cyc(0, 1, 24'h123456 + 24'(i * 3));
        cfg_i = 8'h0C;
        for (int i = 0; i < 4; i++) cyc(0, 1, 24'h654321 + 24'(i));

        // R4 and R5: 8-bit YUV pairing with both orders
        tag = "R4";
        line(8'h10, 9, 0);
        line(8'h13, 12, 0);
        line(8'h11, 10, 0);

        // R6: RGB pass-through
        tag = "R6";
        line(8'h18, 8, 0);

        // R7: reserved format codes
        tag = "R7";
        line(8'h00, 8, 0);
        line(8'h0C, 8, 0);
        line(8'h1C, 8, 0);
        line(8'h44, 10, 0);

        // R8: packed transport, drop after six words, restart on line start
        tag = "R8";
        line(8'h48, 20, 0);
        line(8'h50, 22, 0);
        line(8'h58, 4, 0);
        line(8'h48, 16, 0);

        // R9: odd byte count then a new line restarts the pair phase
        tag = "R9";
        line(8'h12, 5, 0);
        line(8'h12, 6, 0);
        cfg_i = 8'h52;
        cyc(1, 1, 24'hFFFFFF);
        for (int i = 0; i < 9; i++) cyc(0, 1, 24'(i * 17));

        // R10: idle cycles neither emit nor advance the phase or count
        tag = "R10";
        line(8'h10, 20, 50);
        line(8'h48, 30, 40);

        // R11: reserved bits 7 and 5 are ignored
        tag = "R11";
        line(8'hA8, 8, 0);
        line(8'hB0, 8, 0);
        line(8'hF8, 16, 0);

        // Random lines
        for (int n = 0; n < 300; n++) begin
            logic [7:0] c;
            c = 8'($urandom);
            if ($urandom_range(9) < 8) c[4:2] = (c[3]) ? 3'h4 : (c[2] ? 3'h2 : 3'h6);
            tag = tag_for(c);
            line(c, $urandom_range(40, 1), $urandom_range(50));
        end
        cyc(0, 0, 0);
        summary();
    end

endmodule